// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block sits on the read path of a byte-wide flash array and decides what a read returns while an internal program or erase cycle runs. A command decoder hands it single-cycle start events for a byte program or a sector erase, together with the target address, the write data and the sector selection. The start event is raised only once the full command sequence has been written: four write pulses for a program, six for an erase. A timing engine reports the end of the cycle (`eng_done_i`) or a failure such as a timeout (`eng_fail_i`). A sector-protection map masks what may be changed.

While a cycle is active, reads return a status byte instead of array data. The top bit is a polling bit. It shows the complement of the top bit of the byte being programmed, or 0 during an erase. Bit 6 inverts on every read. Bit 5 reports failure. Once the cycle ends, reads return the array contents again. A small behavioural array is included. A program can only clear bits (the stored value becomes old AND new), and an erase sets whole sectors to all ones.

If every sector selected for an erase is protected, nothing is erased. The block still reports busy for a fixed window of `CLK_MHZ*FAKE_US` cycles. A failed operation keeps the status byte up, with bit 5 set, until `clr_i` is pulsed.

Top module: `fsf_status_gen`

## Requirements
- R1: After reset every array byte reads 8'hFF, and reads return array data rather than status.
- R2: While a program is busy, bit 7 of any read is the inverse of bit 7 of the write data. Once `eng_done_i` is seen, the addressed byte holds old AND write data and reads back as such.
- R3: While an erase is busy, bit 7 of any read is 0. Once it completes, every byte of each selected unprotected sector reads 8'hFF, and bytes in other sectors keep their values.
- R4: While busy, bit 6 of the status byte is 0 on the first read after a start and inverts on each following read.
- R5: While idle, two consecutive reads of one address return the same stored byte.
- R6: A program whose target sector is protected is ignored: no busy cycle starts and the byte is unchanged. The sector is address bits [ADDR_W-1 -: SECT_W], indexing `prot_map_i` and `sect_sel_i`.
- R7: An erase whose selected sectors are all protected erases nothing. It shows busy status (bit 7 = 0) for exactly `CLK_MHZ*FAKE_US` cycles after the start edge, then normal data. Under partial protection, only the unprotected selected sectors are erased.
- R8: A program that tries to turn a stored 0 into a 1 still writes the AND result but ends in an error state. In that state bit 5 reads 1, bit 7 keeps its busy meaning and bit 6 keeps toggling, until `clr_i` returns the block to idle. Bit 5 reads 0 in all other busy states.
- R9: `eng_fail_i` during a program or erase enters the error state without changing the array.
- R10: Start events that arrive while the block is not idle are ignored. When both starts arrive together in idle, the program wins.
- R11: During busy or error, bits 4 to 0 of the status byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_start_i | input | 1 | Byte program start pulse |
| erase_start_i | input | 1 | Sector erase start pulse |
| addr_i | input | ADDR_W | Program target address |
| wdata_i | input | DATA_W | Program data |
| sect_sel_i | input | 2**SECT_W | Sectors selected for erase |
| prot_map_i | input | 2**SECT_W | Sector protection map, 1 = protected |
| eng_done_i | input | 1 | Timing engine: cycle finished |
| eng_fail_i | input | 1 | Timing engine: cycle failed or timed out |
| clr_i | input | 1 | Clears the error state |
| rd_i | input | 1 | Read strobe, one per clock per read |
| rd_addr_i | input | ADDR_W | Read address |
| rdata_o | output | DATA_W | Array byte or status byte |

## Verification
The assertions assume that a read strobe lasts one clock per read. They also assume that `eng_done_i` and `eng_fail_i` pulse only after a start, and that the protection map does not change in the cycle a program start is sampled. The bench drives every input at the falling edge and pulses each strobe for exactly one cycle. It raises the engine events only after a start has been taken, and it changes `prot_map_i` only while the block is idle. Start events issued during busy cycles are deliberate, to show that they are ignored.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_FAKE,
    ST_ERR
  } fsf_state_e;
endpackage

// File: rtl/fsf_array.sv
module fsf_array #(
  parameter int ADDR_W = 4,
  parameter int SECT_W = 2,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int NSECT = 1 << SECT_W,
  localparam int SECT_SH = ADDR_W - SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ers_en_i,
  input  logic [NSECT-1:0]  ers_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [DATA_W-1:0] chk_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[i] <= '1;
      end else if (ers_en_i && ers_mask_i[i >> SECT_SH]) begin
        mem[i] <= '1;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
        mem[i] <= mem[i] & wr_data_i; // cells can only be cleared
      end
    end
  end

  assign rd_data_o  = mem[rd_addr_i];
  assign chk_data_o = mem[chk_addr_i];
endmodule

// File: rtl/fsf_seq.sv
module fsf_seq
  import fsf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SECT_W = 2,
  parameter int DATA_W = 8,
  parameter int CLK_MHZ = 200,
  parameter int FAKE_US = 100,
  localparam int NSECT = 1 << SECT_W,
  localparam int FAKE_CYC = CLK_MHZ * FAKE_US,
  localparam int CNT_W = $clog2(FAKE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              prog_prot_i,
  input  logic [NSECT-1:0]  ers_eff_i,
  input  logic              bad_i,
  input  logic              done_i,
  input  logic              fail_i,
  input  logic              clr_i,
  output fsf_state_e        st_o,
  output logic              start_o,
  output logic              op_prog_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [NSECT-1:0]  op_mask_o,
  output logic              wr_en_o,
  output logic              ers_en_o
);
  fsf_state_e st;
  logic       op_bad;
  logic [CNT_W-1:0] cnt;

  assign start_o = (st == ST_IDLE) &&
                   ((prog_start_i && !prog_prot_i) || (!prog_start_i && erase_start_i));
  assign wr_en_o  = (st == ST_PROG)  && done_i && !fail_i;
  assign ers_en_o = (st == ST_ERASE) && done_i && !fail_i;
  assign st_o     = st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      op_bad    <= 1'b0;
      op_prog_o <= 1'b0;
      op_data_o <= '0;
      op_addr_o <= '0;
      op_mask_o <= '0;
      cnt       <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (prog_start_i) begin
            if (!prog_prot_i) begin
              st        <= ST_PROG;
              op_prog_o <= 1'b1;
              op_addr_o <= addr_i;
              op_data_o <= wdata_i;
              op_bad    <= bad_i;
            end
          end else if (erase_start_i) begin
            op_prog_o <= 1'b0;
            op_mask_o <= ers_eff_i;
            if (ers_eff_i == '0) begin
              st  <= ST_FAKE;
              cnt <= CNT_W'(FAKE_CYC - 1);
            end else begin
              st <= ST_ERASE;
            end
          end
        end
        ST_PROG, ST_ERASE: begin
          if (fail_i) st <= ST_ERR;
          else if (done_i) st <= (st == ST_PROG && op_bad) ? ST_ERR : ST_IDLE;
        end
        ST_FAKE: begin
          if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_ERR: if (clr_i) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsf_toggle.sv
module fsf_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_i,
  input  logic busy_i,
  output logic tgl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_o <= 1'b0;
    else if (start_i) tgl_o <= 1'b0;
    else if (rd_i && busy_i) tgl_o <= ~tgl_o;
  end
endmodule

// File: rtl/fsf_status_gen.sv
module fsf_status_gen
  import fsf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SECT_W = 2,
  parameter int DATA_W = 8,
  parameter int CLK_MHZ = 200,
  parameter int FAKE_US = 100,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSECT-1:0]  sect_sel_i,
  input  logic [NSECT-1:0]  prot_map_i,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  fsf_state_e        st;
  logic              start, op_prog, wr_en, ers_en, tgl, busy, prog_prot, bad;
  logic [DATA_W-1:0] op_data, arr_data, chk_data;
  logic [ADDR_W-1:0] op_addr;
  logic [NSECT-1:0]  op_mask, ers_eff;

  assign prog_prot = prot_map_i[addr_i[ADDR_W-1 -: SECT_W]];
  assign ers_eff   = sect_sel_i & ~prot_map_i;
  assign bad       = |(wdata_i & ~chk_data); // 0 -> 1 attempt
  assign busy      = (st != ST_IDLE);

  fsf_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W),
    .CLK_MHZ(CLK_MHZ), .FAKE_US(FAKE_US)
  ) u_seq (
    .clk_i, .rst_ni, .prog_start_i, .erase_start_i, .addr_i, .wdata_i,
    .prog_prot_i(prog_prot), .ers_eff_i(ers_eff), .bad_i(bad),
    .done_i(eng_done_i), .fail_i(eng_fail_i), .clr_i,
    .st_o(st), .start_o(start), .op_prog_o(op_prog), .op_data_o(op_data),
    .op_addr_o(op_addr), .op_mask_o(op_mask), .wr_en_o(wr_en), .ers_en_o(ers_en)
  );

  fsf_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(op_addr), .wr_data_i(op_data),
    .ers_en_i(ers_en), .ers_mask_i(op_mask),
    .rd_addr_i, .rd_data_o(arr_data),
    .chk_addr_i(addr_i), .chk_data_o(chk_data)
  );

  fsf_toggle u_tgl (
    .clk_i, .rst_ni, .start_i(start), .rd_i, .busy_i(busy), .tgl_o(tgl)
  );

  always_comb begin
    rdata_o = arr_data;
    if (busy) begin
      rdata_o = '0;
      rdata_o[DATA_W-1] = op_prog & ~op_data[DATA_W-1];
      rdata_o[DATA_W-2] = tgl;
      rdata_o[DATA_W-3] = (st == ST_ERR);
    end
  end
endmodule

// File: rtl/fsf_status_gen_chk.sv
module fsf_status_gen_chk
  import fsf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SECT_W = 2,
  parameter int DATA_W = 8,
  localparam int NSECT = 1 << SECT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              prog_start_i,
  input logic              clr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NSECT-1:0]  prot_map_i,
  input logic [DATA_W-1:0] rdata_o,
  input fsf_state_e        st_i
);
  AST_ERR_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && st_i == ST_ERR |-> rdata_o[DATA_W-3]); // R8
  AST_ERR_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && st_i != ST_ERR && st_i != ST_IDLE |-> !rdata_o[DATA_W-3]); // R8
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_ERR && !clr_i |=> st_i == ST_ERR); // R8
  AST_ERASE_POLL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (st_i == ST_ERASE || st_i == ST_FAKE) |-> !rdata_o[DATA_W-1]); // R3
  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && st_i != ST_IDLE |-> rdata_o[DATA_W-4:0] == '0); // R11
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && st_i != ST_IDLE) ##1 (rd_i && st_i == $past(st_i))
    |-> rdata_o[DATA_W-2] != $past(rdata_o[DATA_W-2])); // R4
  AST_PROT_PROG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_IDLE && prog_start_i && prot_map_i[addr_i[ADDR_W-1 -: SECT_W]]
    |=> st_i == ST_IDLE); // R6
endmodule

bind fsf_status_gen fsf_status_gen_chk #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .prog_start_i(prog_start_i),
  .clr_i(clr_i), .addr_i(addr_i), .prot_map_i(prot_map_i),
  .rdata_o(rdata_o), .st_i(st)
);

// File: tb/fsf_status_gen_bench.sv
`timescale 1ns/1ps
module fsf_status_gen_bench;
  localparam int AW = 4;
  localparam int SW = 2;
  localparam int DW = 8;
  localparam int MHZ = 200;
  localparam int FUS = 1;
  localparam int FAKE_CYC = MHZ * FUS;
  localparam int NV = 6;
  // {addr, wdata, expected stored byte, expect error}
  localparam logic [AW+2*DW:0] VEC [NV] = '{
    {4'd1,  8'hA5, 8'hA5, 1'b0},
    {4'd1,  8'h24, 8'h24, 1'b0},
    {4'd1,  8'h81, 8'h00, 1'b1},
    {4'd6,  8'h0F, 8'h0F, 1'b0},
    {4'd6,  8'h7E, 8'h0E, 1'b1},
    {4'd12, 8'h00, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_start = 0, erase_start = 0, eng_done = 0, eng_fail = 0, clr = 0, rd = 0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [3:0] sect_sel = '0, prot_map = '0;
  int errors = 0, checks = 0;
  logic finished = 0;

  always #2.5 clk = ~clk;

  fsf_status_gen #(.ADDR_W(AW), .SECT_W(SW), .DATA_W(DW), .CLK_MHZ(MHZ), .FAKE_US(FUS))
  u_fsf_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .erase_start_i(erase_start),
    .addr_i(addr), .wdata_i(wdata), .sect_sel_i(sect_sel), .prot_map_i(prot_map),
    .eng_done_i(eng_done), .eng_fail_i(eng_fail), .clr_i(clr), .rd_i(rd),
    .rd_addr_i(rd_addr), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                     input logic [DW-1:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, mask);
    end
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd = 1'b1; rd_addr = a;
    #1 d = rdata;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    prog_start = 1'b1; addr = a; wdata = d;
    @(negedge clk) prog_start = 1'b0;
  endtask

  task automatic erase(input logic [3:0] sel);
    erase_start = 1'b1; sect_sel = sel;
    @(negedge clk) erase_start = 1'b0;
  endtask

  task automatic finish_op(input logic fail);
    eng_done = ~fail; eng_fail = fail;
    @(negedge clk) begin eng_done = 1'b0; eng_fail = 1'b0; end
  endtask

  task automatic clear_err();
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents
    rd_byte(4'd0, d);  chk("R1", d, 8'hFF, 8'hFF);
    rd_byte(4'd15, d); chk("R1", d, 8'hFF, 8'hFF);

    // table walk: programs, polling, toggle, 0->1 errors
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] va;
      logic [DW-1:0] vw, vf;
      logic ve;
      {va, vw, vf, ve} = VEC[i];
      prog(va, vw);
      rd_byte(va, d);  chk("R2", d, {~vw[7], 7'b0}, 8'hFF);           // R4 first read bit6=0
      rd_byte(4'd9, d); chk("R4", d, {~vw[7], 1'b1, 6'b0}, 8'hFF);
      finish_op(1'b0);
      if (ve) begin
        rd_byte(va, d);  chk("R8", d, {~vw[7], 1'b0, 1'b1, 5'b0}, 8'hBF);
        rd_byte(va, d2); chk("R8", d2, {~d[6], 6'b0}, 8'h40);
        clear_err();
      end
      rd_byte(va, d); chk("R2", d, vf, 8'hFF);
    end
    // array now: [1]=00, [6]=0E, [12]=00, rest FF

    // R5 stable idle reads
    rd_byte(4'd6, d); rd_byte(4'd6, d2);
    chk("R5", d2, d, 8'hFF);
    chk("R5", d, 8'h0E, 8'hFF);

    // R6 protected program ignored (sector 1 = addresses 4..7)
    prot_map = 4'b0010;
    prog(4'd6, 8'h00);
    rd_byte(4'd6, d); chk("R6", d, 8'h0E, 8'hFF);
    rd_byte(4'd6, d); chk("R6", d, 8'h0E, 8'hFF);

    // R7 partial protection erase: sectors 0,1 selected, 1 protected
    erase(4'b0011);
    rd_byte(4'd6, d);  chk("R3", d, 8'h00, 8'hFF);
    rd_byte(4'd6, d);  chk("R4", d, 8'h40, 8'hFF);
    // R10 starts during busy ignored
    prog(4'd8, 8'h00);
    erase(4'b1000);
    finish_op(1'b0);
    rd_byte(4'd1, d);  chk("R3", d, 8'hFF, 8'hFF);
    rd_byte(4'd6, d);  chk("R7", d, 8'h0E, 8'hFF);
    rd_byte(4'd8, d);  chk("R10", d, 8'hFF, 8'hFF);
    rd_byte(4'd12, d); chk("R10", d, 8'h00, 8'hFF);
    prot_map = 4'b0000;

    // R9 engine failure on erase: no change, error flag
    erase(4'b1000);
    finish_op(1'b1);
    rd_byte(4'd12, d); chk("R9", d, 8'h20, 8'hBF);
    rd_byte(4'd12, d); chk("R11", d, 8'h20, 8'hBF);
    clear_err();
    rd_byte(4'd12, d); chk("R9", d, 8'h00, 8'hFF);

    // R7 all-protected erase: busy window of FAKE_CYC cycles
    prot_map = 4'b0110;
    erase(4'b0100);
    repeat (FAKE_CYC - 2) @(negedge clk);
    rd_byte(4'd8, d);  chk("R7", d, 8'h00, 8'hFF);
    rd_byte(4'd8, d);  chk("R7", d, 8'h40, 8'hFF);
    rd_byte(4'd8, d);  chk("R7", d, 8'hFF, 8'hFF);
    rd_byte(4'd8, d);  chk("R7", d, 8'hFF, 8'hFF);
    prot_map = 4'b0000;

    // R10 simultaneous starts: program wins
    prog_start = 1'b1; erase_start = 1'b1; addr = 4'd13; wdata = 8'h55; sect_sel = 4'b1000;
    @(negedge clk) begin prog_start = 1'b0; erase_start = 1'b0; end
    rd_byte(4'd13, d); chk("R10", d, 8'h80, 8'hFF);
    finish_op(1'b0);
    rd_byte(4'd13, d); chk("R10", d, 8'h55, 8'hFF);
    rd_byte(4'd14, d); chk("R10", d, 8'hFF, 8'hFF);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule